// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a serial port with one control register and a data buffer. Writing the buffer starts a transmission. The buffer output holds the last byte that was received. Two mode bits pick one of four modes:

- mode 0 is a synchronous shift register with a fixed shift clock;
- mode 1 is an asynchronous 8-bit frame at a timer-derived rate;
- mode 2 is an asynchronous 9-bit frame at a fixed rate;
- mode 3 is an asynchronous 9-bit frame at a timer-derived rate.

In the 9-bit modes the ninth bit is programmable on transmit and is captured on receive. A rate-doubling input scales both the fixed and the timer-derived bit rates.

The asynchronous modes share a sample tick that runs at 16 ticks per bit. In mode 2 the tick comes from a divider on the block clock. In modes 1 and 3 it comes from the overflow pulses of an external timer. The receiver takes three samples around the middle of each bit and keeps the majority. When a frame finishes, hardware sets a transmit-done flag or a receive-done flag, and only software writes clear them. In the 9-bit modes an address-filter bit discards frames whose ninth bit is 0.

Top module: `serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00, `txd` is 1 and `rxd_oe` is 0. Control bits, from bit 7 down: mode high, mode low, address filter, receive enable, transmit ninth bit, received ninth bit, TI, RI.
- R2: In mode 0, a buffer write shifts the byte out on `rxd_o` LSB first, with `rxd_oe` high. Each bit lasts SHIFT_DIV clocks, and the shift clock on `txd` is low for the first half of each bit and high for the second half. TI reads 1 exactly 8*SHIFT_DIV clocks after the write edge.
- R3: In mode 0, a reception starts when receive enable is 1 and RI is 0. Each bit is sampled at the end of the high phase of the shift clock, LSB first. The byte goes to the receive buffer and RI is set.
- R4: An asynchronous frame is sent in this order: a 0 start bit, eight data bits LSB first, in modes 2 and 3 the transmit ninth bit (control bit 3), then a 1 stop bit. TI is set at the end of the stop bit, and the line then rests at 1.
- R5: In mode 2 a bit lasts 16*FIX_DIV clocks, or half of that when `dbl` is 1.
- R6: In modes 1 and 3 a bit lasts 32 timer overflow pulses, or 16 pulses when `dbl` is 1.
- R7: With receive enable set, a received asynchronous frame loads its byte into the buffer and sets RI. RB8 (control bit 2) takes the stop bit in mode 1 and the ninth bit in modes 2 and 3.
- R8: With receive enable clear, a frame on `rxd_in` leaves RI at 0 and leaves the receive buffer unchanged.
- R9: In modes 2 and 3 with the address filter (control bit 5) set, a frame whose ninth bit is 0 is dropped, with no change to RI or the buffer. A frame whose ninth bit is 1 is accepted.
- R10: Once TI or RI is set, it stays set until a control write clears it.
- R11: A buffer write while an asynchronous transmission is in progress is ignored. The frame in flight is unchanged and no further frame follows.
- R12: A control write loads all control bits. If hardware sets TI or RI in the same cycle, that flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| buf_we | input | 1 | Buffer write strobe, starts a transmission |
| buf_wdata | input | 8 | Byte to transmit |
| dbl | input | 1 | Rate-doubling bit |
| tmr_ovf | input | 1 | Timer overflow pulse, one clock wide |
| rxd_in | input | 1 | Serial data in |
| ctl_q | output | 8 | Control register contents |
| rxbuf_q | output | 8 | Last received byte |
| txd | output | 1 | Serial data out (async), shift clock (mode 0) |
| rxd_o | output | 1 | Mode 0 shifted data out |
| rxd_oe | output | 1 | Mode 0 data output enable |

## Verification
A software write to the control register and a hardware flag set can land on the same clock edge. The bench uses mode 0 to provoke this, because there TI rises exactly 8*SHIFT_DIV clocks after the buffer write. It places a control write that clears TI on that edge and checks that TI still reads 1 while the other bits take the written value. A second run puts the same write one cycle later and expects TI to be cleared. Receive-done and transmit-done also complete close together during loopback frames, and each flag is checked on its own.

// File: rtl/serial_port.sv
module serial_port #(
  parameter int SHIFT_DIV = 12,
  parameter int FIX_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       buf_we,
  input  logic [7:0] buf_wdata,
  input  logic       dbl,
  input  logic       tmr_ovf,
  input  logic       rxd_in,
  output logic [7:0] ctl_q,
  output logic [7:0] rxbuf_q,
  output logic       txd,
  output logic       rxd_o,
  output logic       rxd_oe
);
  localparam int DW   = $clog2(SHIFT_DIV);
  localparam int FW   = $clog2(FIX_DIV);
  localparam int HALF = SHIFT_DIV / 2;

  logic [7:0]    ctl, rxbuf;
  logic          rs1, rs2;
  logic [FW-1:0] fcnt;
  logic          ovf_t;
  logic          m0_act, m0_tx;
  logic [DW-1:0] m0_div;
  logic [2:0]    m0_bit;
  logic [7:0]    m0_sh;
  logic          tx_act;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_ph, tx_cnt;
  logic          rx_act;
  logic [3:0]    rx_ph, rx_bit;
  logic [8:0]    rx_sh;
  logic [1:0]    rx_v;

  wire [1:0] mode  = ctl[7:6];
  wire       nine  = ctl[7];
  wire       m0    = (mode == 2'b00);
  wire [3:0] last  = nine ? 4'd10 : 4'd9;

  wire [FW-1:0] flim     = dbl ? FW'(FIX_DIV/2 - 1) : FW'(FIX_DIV - 1);
  wire          tick_fix = (fcnt >= flim);
  wire          tick_var = tmr_ovf & (dbl | ovf_t);
  wire          s_tick   = (mode == 2'b10) ? tick_fix : (ctl[6] & tick_var);

  wire m0_go_tx = m0 & ~m0_act & buf_we;
  wire m0_go_rx = m0 & ~m0_act & ~buf_we & ctl[4] & ~ctl[0];
  wire m0_step  = m0_act & (m0_div == DW'(SHIFT_DIV - 1));
  wire m0_end   = m0_step & (m0_bit == 3'd7);

  wire tx_go  = ~m0 & ~tx_act & buf_we;
  wire tx_end = tx_act & s_tick & (tx_ph == 4'd15) & (tx_cnt == last);

  wire rx_go   = ~m0 & ~rx_act & ctl[4] & s_tick & ~rs2;
  wire rx_dec  = rx_act & s_tick & (rx_ph == 4'd9);
  wire rx_vote = (rx_v[0] & rx_v[1]) | (rx_v[0] & rs2) | (rx_v[1] & rs2);
  wire rx_fin  = rx_dec & (rx_bit == last);
  wire rx_keep = ~nine | ~ctl[5] | rx_sh[8];

  wire ti_set = (m0_end & m0_tx) | tx_end;
  wire ri_set = (m0_end & ~m0_tx) | (rx_fin & rx_keep);

  assign ctl_q   = ctl;
  assign rxbuf_q = rxbuf;
  assign rxd_o   = m0_sh[0];
  assign rxd_oe  = m0 & m0_act & m0_tx;
  assign txd     = m0 ? (m0_act ? (m0_div >= DW'(HALF)) : 1'b1)
                      : (tx_act ? tx_sh[0] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b1;
      rs2   <= 1'b1;
      fcnt  <= '0;
      ovf_t <= 1'b0;
    end else begin
      rs1   <= rxd_in;
      rs2   <= rs1;
      fcnt  <= tick_fix ? '0 : fcnt + 1'b1;
      if (tmr_ovf) ovf_t <= ~ovf_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      rxbuf <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      if (ti_set) ctl[1] <= 1'b1;
      if (ri_set) ctl[0] <= 1'b1;
      if (rx_fin & rx_keep) ctl[2] <= nine ? rx_sh[8] : rx_vote;
      if (m0_end & ~m0_tx)
        rxbuf <= {rs2, m0_sh[7:1]};
      else if (rx_fin & rx_keep)
        rxbuf <= nine ? rx_sh[7:0] : rx_sh[8:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_act <= 1'b0;
      m0_tx  <= 1'b0;
      m0_div <= '0;
      m0_bit <= '0;
      m0_sh  <= '1;
    end else if (!m0) begin
      m0_act <= 1'b0;
    end else if (m0_go_tx || m0_go_rx) begin
      m0_act <= 1'b1;
      m0_tx  <= m0_go_tx;
      m0_div <= '0;
      m0_bit <= '0;
      m0_sh  <= m0_go_tx ? buf_wdata : 8'hFF;
    end else if (m0_act) begin
      if (m0_step) begin
        m0_div <= '0;
        m0_sh  <= {m0_tx ? 1'b1 : rs2, m0_sh[7:1]};
        m0_bit <= m0_bit + 1'b1;
        if (m0_bit == 3'd7) m0_act <= 1'b0;
      end else begin
        m0_div <= m0_div + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act <= 1'b0;
      tx_sh  <= '1;
      tx_ph  <= '0;
      tx_cnt <= '0;
    end else if (m0) begin
      tx_act <= 1'b0;
    end else if (tx_go) begin
      tx_act <= 1'b1;
      tx_sh  <= nine ? {1'b1, ctl[3], buf_wdata, 1'b0} : {2'b11, buf_wdata, 1'b0};
      tx_ph  <= '0;
      tx_cnt <= '0;
    end else if (tx_act && s_tick) begin
      tx_ph <= tx_ph + 1'b1;
      if (tx_ph == 4'd15) begin
        tx_sh  <= {1'b1, tx_sh[10:1]};
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == last) tx_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0;
      rx_ph  <= '0;
      rx_bit <= '0;
      rx_sh  <= '0;
      rx_v   <= '0;
    end else if (m0) begin
      rx_act <= 1'b0;
    end else if (rx_go) begin
      rx_act <= 1'b1;
      rx_ph  <= '0;
      rx_bit <= '0;
    end else if (rx_act && s_tick) begin
      rx_ph <= rx_ph + 1'b1;
      if (rx_ph == 4'd7) rx_v[0] <= rs2;
      if (rx_ph == 4'd8) rx_v[1] <= rs2;
      if (rx_ph == 4'd15) rx_bit <= rx_bit + 1'b1;
      if (rx_dec) begin
        if (rx_bit == 4'd0 && rx_vote) rx_act <= 1'b0;
        else if (rx_bit == last) rx_act <= 1'b0;
        else if (rx_bit != 4'd0) rx_sh <= {rx_vote, rx_sh[8:1]};
      end
    end
  end
endmodule

module serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_q,
  input logic [7:0] rxbuf_q,
  input logic       txd
);
  // R10
  ti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[1]) |-> $past(ctl_we));
  // R10
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[0]) |-> $past(ctl_we));
  // R12
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q[7:3] == $past(ctl_wdata[7:3])));
  // R12
  flag_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[1]) |=> ctl_q[1]);
  // R4
  ti_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_q[1]) && !$past(ctl_we)) |-> txd);
  // R7
  buf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxbuf_q) |-> ctl_q[0]);
endmodule

bind serial_port serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_q(ctl_q), .rxbuf_q(rxbuf_q), .txd(txd)
);

// File: tb/tb_serial_port.sv
module tb_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, buf_we = 1'b0, dbl = 1'b0, tmr_ovf = 1'b0;
  logic [7:0] ctl_wdata = '0, buf_wdata = '0;
  logic rxd_drv = 1'b1, loop_en = 1'b0, ovf_en = 1'b0;
  logic [7:0] ctl_q, rxbuf_q;
  logic txd, rxd_o, rxd_oe, rxd_in;
  int total = 0, fails = 0;

  assign rxd_in = loop_en ? txd : rxd_drv;
  always #5 clk = ~clk;
  always @(negedge clk) tmr_ovf = ovf_en ? ~tmr_ovf : 1'b0;

  serial_port dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .dbl(dbl), .tmr_ovf(tmr_ovf),
    .rxd_in(rxd_in), .ctl_q(ctl_q), .rxbuf_q(rxbuf_q), .txd(txd),
    .rxd_o(rxd_o), .rxd_oe(rxd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_we = 1'b1; buf_wdata = v;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wait_ti(output int n);
    n = 0;
    while (!ctl_q[1] && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    chk(rxbuf_q == 8'h00, "R1 rxbuf", rxbuf_q, 0);
    chk(txd == 1'b1 && rxd_oe == 1'b0, "R1 lines", {txd, rxd_oe}, 2);
  endtask

  task automatic t_m0_tx;
    logic [7:0] got = '0;
    int n = 0, k = 0;
    logic prev;
    bit oe_ok = 1'b1;
    wr_ctl(8'h00);
    wr_buf(8'h4B);
    prev = txd;
    while (!ctl_q[1] && n < 400) begin
      @(negedge clk); n++;
      if (txd && !prev && k < 8) begin
        got[k] = rxd_o;
        if (!rxd_oe) oe_ok = 1'b0;
        k++;
      end
      prev = txd;
    end
    chk(got == 8'h4B, "R2 shifted byte", got, 8'h4B);
    chk(k == 8 && oe_ok, "R2 clock edges and oe", k, 8);
    chk(n == 96, "R2 TI timing", n, 96);
    wr_ctl(8'h00);
  endtask

  task automatic t_m0_rx;
    logic [7:0] b = 8'hC6;
    int n = 0, f = 0;
    logic prev;
    rxd_drv = b[0];
    wr_ctl(8'h10);
    prev = txd;
    while (!ctl_q[0] && n < 400) begin
      @(negedge clk); n++;
      if (!txd && prev) begin
        f++;
        if (f >= 2 && f <= 8) rxd_drv = b[f-1];
      end
      prev = txd;
    end
    chk(ctl_q[0] == 1'b1, "R3 RI", ctl_q[0], 1);
    chk(rxbuf_q == b, "R3 byte", rxbuf_q, b);
    rxd_drv = 1'b1;
    wr_ctl(8'h00);
  endtask

  task automatic t_collide;
    wr_ctl(8'h00);
    wr_buf(8'h77);
    repeat (95) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'h28;
    @(negedge clk); ctl_we = 1'b0;
    chk(ctl_q == 8'h2A, "R12 same-cycle set wins", ctl_q, 8'h2A);
    wr_ctl(8'h00);
    wr_buf(8'h77);
    repeat (96) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'h28;
    @(negedge clk); ctl_we = 1'b0;
    chk(ctl_q == 8'h28, "R12 later write clears", ctl_q, 8'h28);
    wr_ctl(8'h00);
  endtask

  task automatic t_async_tx;
    logic [10:0] fr = '0;
    logic [10:0] exp = {1'b1, 1'b1, 8'h35, 1'b0};
    int n;
    dbl = 1'b0;
    wr_ctl(8'h88);
    wr_buf(8'h35);
    repeat (32) @(negedge clk);
    fr[0] = txd;
    for (int k = 1; k < 11; k++) begin
      repeat (64) @(negedge clk);
      fr[k] = txd;
    end
    wait_ti(n);
    n = n + 32 + 640;
    chk(fr == exp, "R4 frame bits", fr, exp);
    chk(txd == 1'b1, "R4 line idle", txd, 1);
    chk(n >= 696 && n <= 712, "R5 mode2 frame length", n, 704);
    wr_ctl(8'h80);
  endtask

  task automatic frame_len(input logic [7:0] c, input logic d, input int exp, input string req);
    int n;
    dbl = d;
    wr_ctl(c);
    wr_buf(8'h3C);
    wait_ti(n);
    chk(n >= exp - 8 && n <= exp + 8, req, n, exp);
    wr_ctl(c);
  endtask

  task automatic t_rates;
    ovf_en = 1'b1;
    frame_len(8'h80, 1'b1, 352, "R5 mode2 doubled");
    frame_len(8'h40, 1'b0, 640, "R6 mode1 normal");
    frame_len(8'h40, 1'b1, 320, "R6 mode1 doubled");
    frame_len(8'hC0, 1'b1, 352, "R6 mode3 doubled");
  endtask

  task automatic t_rx;
    int n;
    loop_en = 1'b1; ovf_en = 1'b1; dbl = 1'b1;
    wr_ctl(8'h50);
    wr_buf(8'h9D); wait_ti(n);
    chk(ctl_q[0] && rxbuf_q == 8'h9D, "R7 mode1 byte", rxbuf_q, 8'h9D);
    chk(ctl_q[2] == 1'b1, "R7 mode1 stop in RB8", ctl_q[2], 1);
    wr_ctl(8'hD0);
    wr_buf(8'h62); wait_ti(n);
    chk(ctl_q[0] && rxbuf_q == 8'h62 && !ctl_q[2], "R7 mode3 ninth 0", {ctl_q[2], rxbuf_q}, 8'h62);
    wr_ctl(8'hD8);
    wr_buf(8'hA1); wait_ti(n);
    chk(ctl_q[0] && rxbuf_q == 8'hA1 && ctl_q[2], "R7 mode3 ninth 1", {ctl_q[2], rxbuf_q}, 9'h1A1);
    wr_ctl(8'h80);
  endtask

  task automatic t_noren;
    int n;
    loop_en = 1'b1; dbl = 1'b1;
    wr_ctl(8'h80);
    wr_buf(8'h0F); wait_ti(n);
    repeat (40) @(negedge clk);
    chk(!ctl_q[0] && rxbuf_q == 8'hA1, "R8 ignored frame", {ctl_q[0], rxbuf_q}, 8'hA1);
    wr_ctl(8'h80);
  endtask

  task automatic t_sm2;
    int n;
    loop_en = 1'b1; dbl = 1'b1;
    wr_ctl(8'hB0);
    wr_buf(8'h11); wait_ti(n);
    repeat (40) @(negedge clk);
    chk(!ctl_q[0] && rxbuf_q == 8'hA1, "R9 ninth 0 dropped", {ctl_q[0], rxbuf_q}, 8'hA1);
    wr_ctl(8'hB8);
    wr_buf(8'h22); wait_ti(n);
    chk(ctl_q[0] && rxbuf_q == 8'h22 && ctl_q[2], "R9 ninth 1 kept", {ctl_q[2], rxbuf_q}, 9'h122);
    wr_ctl(8'h80);
  endtask

  task automatic t_busy;
    int n;
    loop_en = 1'b1; dbl = 1'b1;
    wr_ctl(8'h90);
    wr_buf(8'h5A);
    repeat (10) @(negedge clk);
    wr_buf(8'hFF);
    wait_ti(n);
    chk(rxbuf_q == 8'h5A, "R11 frame unchanged", rxbuf_q, 8'h5A);
    repeat (600) @(negedge clk);
    chk(ctl_q[1] && ctl_q[0], "R10 flags held", ctl_q[1:0], 3);
    chk(rxbuf_q == 8'h5A, "R11 no second frame", rxbuf_q, 8'h5A);
    wr_ctl(8'h90);
    chk(ctl_q[1:0] == 2'b00, "R10 write clears", ctl_q[1:0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_m0_tx();
    t_m0_rx();
    t_collide();
    t_async_tx();
    t_rates();
    t_rx();
    t_noren();
    t_sm2();
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule